// File: doc/BRIEF.md
# Quad-Lane Receive Delay Training Controller

This controller calibrates the capture timing of the four data-in lines of a quad serial flash read path. It owns a packed vector of per-lane sample delays, each 0 to 7 steps, that the receive capture logic applies to its data lines. When started, it trains one lane at a time. For each candidate delay of the lane under test, it issues one full-page read of a reference page and records whether the page compared equal to the expected pattern. That page was written beforehand at a safe low clock rate.

After all eight candidates of a lane have been tried, the controller does not take the first passing delay. It commits the centre of the longest contiguous run of passing delays, which leaves the largest margin on both sides. A lane with no passing delay falls back to the default of 4 and raises a sticky fail flag. A one-cycle done pulse marks the end of a run. The flash command sequencing, the page compare itself and the clock generation sit outside the block.

Top module: `rx_lane_delay_trainer`

## Requirements
- R1: A synchronous reset sets every lane delay to 4 (delay vector 0x924), clears all fail flags and drives busy, done and rd_req low.
- R2: Lane i owns bits [3i+2:3i] of the delay vector, so lane 0 owns [2:0] and lane 3 owns [11:9]. Each field holds a value from 0 to 7.
- R3: A start pulse while idle begins a run. Lanes are trained in the order 0, 1, 2, 3, and each lane sweeps the candidates 0 to 7 in ascending order. Each candidate produces exactly one rd_req, one cycle wide, so a run produces 32 requests.
- R4: While a lane is under test, its field equals the current candidate and every other field holds its value. The vector changes only after a response arrives, never between an rd_req and its rd_resp.
- R5: A lane commits the centre of its longest contiguous run of passing delays. The centre is (first + last) / 2, rounded down.
- R6: When two passing runs have the same length, the run at the lower delays wins.
- R7: A lane with no passing delay commits 4 and sets its bit in lane_fail. The bit stays set through later runs until a reset.
- R8: After lane 3 commits, done pulses high for exactly one cycle with busy already low, and the full trained vector is visible on dly_vec.
- R9: A start pulse during a run is ignored, and so is an rd_resp while no read is outstanding. Neither changes the request count or the delay vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a training run (only while idle) |
| busy | output | 1 | A training run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_req | output | 1 | One-cycle request for a full-page reference read |
| rd_resp | input | 1 | Read finished; rd_match is valid |
| rd_match | input | 1 | Returned page equals the reference pattern |
| dly_vec | output | 12 | Packed per-lane sample delays, 3 bits per lane |
| lane_fail | output | 4 | Sticky per-lane "no passing delay" flags |

## Verification
The hardest outcome to reach from the ports is the choice among passing delays, because it depends on the whole eight-read history of a lane. The bench therefore acts as the flash side. It answers every request from a per-lane pass mask taken from a table row. The rows are chosen to cover a full pass, a single pass at either end, equal-length runs and lanes that never pass. While answering, the bench also predicts the whole vector at each request, which checks the hold of the other lanes. It injects a stray start and a stray response in the middle of a run and while idle.

// File: rtl/rx_lane_delay_trainer.sv
module rx_lane_delay_trainer #(
  parameter int LANES = 4,
  parameter int DW    = 3,
  parameter int DEF   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                rd_req,
  input  logic                rd_resp,
  input  logic                rd_match,
  output logic [LANES*DW-1:0] dly_vec,
  output logic [LANES-1:0]    lane_fail
);
  localparam int NC = 1 << DW;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  typedef enum logic [1:0] {IDLE, REQ, WAIT, EVAL} st_t;

  st_t            st;
  logic [LW-1:0]  lane;
  logic [DW-1:0]  cand;
  logic [NC-1:0]  mask;
  logic           done_r;
  logic [DW-1:0]  pick;
  logic [DW:0]    run_len, best_len;
  logic [DW-1:0]  run_st, best_st;

  assign busy   = (st != IDLE);
  assign rd_req = (st == REQ);
  assign done   = done_r;

  always_comb begin
    run_len  = '0;
    best_len = '0;
    run_st   = '0;
    best_st  = '0;
    for (int i = 0; i < NC; i++) begin
      if (mask[i]) begin
        if (run_len == '0) run_st = DW'(i);
        run_len = run_len + 1'b1;
        if (run_len > best_len) begin
          best_len = run_len;
          best_st  = run_st;
        end
      end else begin
        run_len = '0;
      end
    end
    pick = best_st + DW'((best_len - 1'b1) >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= IDLE;
      lane      <= '0;
      cand      <= '0;
      mask      <= '0;
      done_r    <= 1'b0;
      lane_fail <= '0;
      dly_vec   <= {LANES{DW'(DEF)}};
    end else begin
      done_r <= 1'b0;
      case (st)
        IDLE: if (start) begin
          lane           <= '0;
          cand           <= '0;
          mask           <= '0;
          dly_vec[0+:DW] <= '0;
          st             <= REQ;
        end
        REQ: st <= WAIT;
        WAIT: if (rd_resp) begin
          mask[cand] <= rd_match;
          if (cand == DW'(NC-1)) begin
            st <= EVAL;
          end else begin
            cand                           <= cand + 1'b1;
            dly_vec[int'(lane)*DW +: DW]   <= cand + 1'b1;
            st                             <= REQ;
          end
        end
        EVAL: begin
          if (mask == '0) begin
            dly_vec[int'(lane)*DW +: DW] <= DW'(DEF);
            lane_fail[lane]              <= 1'b1;
          end else begin
            dly_vec[int'(lane)*DW +: DW] <= pick;
          end
          if (lane == LW'(LANES-1)) begin
            done_r <= 1'b1;
            st     <= IDLE;
          end else begin
            lane                               <= lane + 1'b1;
            cand                               <= '0;
            mask                               <= '0;
            dly_vec[(int'(lane)+1)*DW +: DW]   <= '0;
            st                                 <= REQ;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module rx_lane_delay_trainer_chk #(
  parameter int LANES = 4,
  parameter int DW    = 3,
  parameter int DEF   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                done,
  input logic                rd_req,
  input logic [LANES*DW-1:0] dly_vec,
  input logic [LANES-1:0]    lane_fail
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    $past(rst) |-> (dly_vec == {LANES{DW'(DEF)}} && lane_fail == '0 && !busy && !done && !rd_req));
  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R4
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_req) |-> $stable(dly_vec));
  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lane_fail & $past(lane_fail)) == $past(lane_fail)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));
endmodule

bind rx_lane_delay_trainer rx_lane_delay_trainer_chk #(.LANES(LANES), .DW(DW), .DEF(DEF)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .rd_req(rd_req),
  .dly_vec(dly_vec), .lane_fail(lane_fail)
);

// File: tb/rx_lane_delay_trainer_tb.sv
module rx_lane_delay_trainer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_resp = 1'b0;
  logic        rd_match = 1'b0;
  logic        busy, done, rd_req;
  logic [11:0] dly_vec;
  logic [3:0]  lane_fail;

  int errors = 0;
  int checks = 0;
  int req_cnt = 0;

  always #2 clk = ~clk;

  rx_lane_delay_trainer u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_req(rd_req), .rd_resp(rd_resp), .rd_match(rd_match),
    .dly_vec(dly_vec), .lane_fail(lane_fail)
  );

  always @(posedge clk) if (rd_req) req_cnt <= req_cnt + 1;

  // {mask lane3, lane2, lane1, lane0, expected vector, expected fail flags}
  localparam logic [47:0] TBL [4] = '{
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 12'h6DB, 4'h0},  // R5 full pass -> 3
    {8'h0E, 8'h80, 8'h01, 8'h3C, 12'h5C3, 4'h0},  // R5 R2 edges and inner runs
    {8'h7B, 8'h5A, 8'hE7, 8'h33, 12'h8C8, 4'h0},  // R6 equal-length runs
    {8'hC0, 8'h00, 8'h40, 8'h00, 12'hD34, 4'h5}   // R7 lanes with no pass
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mid_vec(input logic [11:0] cur, input logic [11:0] fin,
                                          input int l, input int c);
    logic [11:0] v;
    for (int i = 0; i < 4; i++)
      v[3*i +: 3] = (i < l) ? fin[3*i +: 3] : (i == l) ? 3'(c) : cur[3*i +: 3];
    return v;
  endfunction

  task automatic run(input logic [31:0] masks, input logic [11:0] cur,
                     input logic [11:0] fin, input logic [3:0] fail_exp, input bit glitch);
    int bad = 0;
    int req0 = req_cnt;
    int guard;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 32; k++) begin
      guard = 0;
      while (!rd_req && guard < 50) begin @(negedge clk); guard++; end
      if (dly_vec !== mid_vec(cur, fin, k / 8, k % 8)) bad++;
      @(negedge clk);
      @(negedge clk);
      rd_resp  = 1'b1;
      rd_match = masks[8*(k/8) + (k%8)];
      if (glitch && k == 3) start = 1'b1;   // R9 start while busy
      @(negedge clk);
      rd_resp = 1'b0;
      start   = 1'b0;
      if (glitch && k == 10) begin         // R9 response with nothing outstanding
        rd_resp = 1'b1;
        rd_match = 1'b1;
        @(negedge clk);
        rd_resp = 1'b0;
      end
    end
    guard = 0;
    while (!done && guard < 50) begin @(negedge clk); guard++; end
    check("R4 sweep and hold mismatches", 32'(bad), 32'd0);
    check("R8 done with busy low", {30'd0, done, busy}, 32'b10);
    check("R8 final vector", 32'(dly_vec), 32'(fin));
    check("R7 fail flags", 32'(lane_fail), 32'(fail_exp));
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
    check("R3 R9 request count", 32'(req_cnt - req0), 32'd32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [11:0] cur;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset vector", 32'(dly_vec), 32'h924);
    check("R1 reset flags", {27'd0, lane_fail, busy, done}, 32'd0);
    check("R1 reset rd_req", 32'(rd_req), 32'd0);

    rd_resp = 1'b1; rd_match = 1'b1;
    @(negedge clk);
    rd_resp = 1'b0;
    @(negedge clk);
    check("R9 idle response ignored", {19'd0, busy, dly_vec}, {19'd0, 1'b0, 12'h924});
    check("R9 idle no request", 32'(req_cnt), 32'd0);

    cur = 12'h924;
    for (int v = 0; v < 4; v++) begin
      run(TBL[v][47:16], cur, TBL[v][15:4], TBL[v][3:0], v == 1);
      cur = TBL[v][15:4];
      repeat (2) @(negedge clk);
    end

    // R7 flags persist across a fully passing run
    run(32'hFFFFFFFF, cur, 12'h6DB, 4'h5, 1'b0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after training vector", 32'(dly_vec), 32'h924);
    check("R1 R7 reset clears flags", 32'(lane_fail), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule